// File: doc/BRIEF.md
# Chained Down-Counting Timer Group with Edge-Armed Start

This block holds pairs of 8-bit down-counters. Each counter has its own reload register. When a counter steps from zero, it reloads itself and raises a sticky interrupt flag. A single-cycle underflow pulse is also visible at the block edge. The block divides the system clock into an instruction-rate tick. A prescaler divides that tick again, by one of two ratios, to give a slower tick. Each counter picks its count source from a 2-bit selector: the instruction tick, the prescaler tick, or (for the second counter of a pair only) the underflow pulse of its partner. Selecting the partner cascades the two into a longer timer.

The first counter of every pair can be held back by a start synchroniser. An external pin passes through a two-flop synchroniser and an edge detector. The selected edge sets an arm latch, and the counter then runs until the latch is cleared. The edge can be rising, falling or both. Software writes a counter value through a per-timer write strobe, which loads the reload register and the counter together.

Top module: `cascade_timer_group`

## Requirements
- R1: With the default divider parameters the instruction tick occurs once every 6 clock cycles. A timer with selector code 00 and reload value N underflows once every 6*(N+1) cycles.
- R2: A timer that counts while at 0x00 loads its reload value instead of wrapping. It drives its underflow output high for exactly one cycle. A reload value of 0 underflows on every count tick.
- R3: Selector code 01 counts prescaler ticks. The prescaler divides the instruction tick by 4 when `psc_div16` is 0 and by 16 when it is 1.
- R4: Selector code 10 counts the underflow pulses of the pair partner on the second timer of a pair (timer index 1, 3, ...). On the first timer of a pair, code 10 selects no source. Code 11 selects no source on any timer.
- R5: While `run_en` for a timer is 0, that timer neither counts nor underflows.
- R6: A timer's interrupt flag is 0 after reset. It sets in the cycle after that timer's underflow pulse and stays set until `irq_clr` for that timer is pulsed. A simultaneous underflow wins over the clear.
- R7: A reload write loads both the reload register and the counter. It takes priority over counting in the same cycle.
- R8: When `arm_en` of a pair is 1 and its arm latch is clear, the first timer of the pair holds its value. `arm_clr` clears the latch.
- R9: The pin of a pair is synchronised by two flops. With `arm_both`=1 either edge sets the latch. Otherwise `arm_rising`=1 selects the rising edge and 0 selects the falling edge. The synchroniser flops reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_we | input | NT | Per-timer write strobe for reload register and counter |
| reload_wdata | input | W | Value written by `reload_we` |
| src_sel | input | 2*NT | Count source code per timer, bits [2i+1:2i] for timer i |
| run_en | input | NT | Per-timer count enable; 0 stops the count source |
| psc_div16 | input | 1 | Prescaler ratio: 0 divides by 4, 1 by 16 |
| arm_en | input | NP | Per-pair start synchronisation enable |
| arm_both | input | NP | Per-pair both-edge arming |
| arm_rising | input | NP | Per-pair edge polarity when one-sided |
| arm_clr | input | NP | Per-pair arm latch clear |
| arm_pin | input | NP | Per-pair asynchronous external pin |
| irq_clr | input | NT | Per-timer interrupt flag clear |
| irq_flag | output | NT | Per-timer sticky interrupt flag |
| underflow | output | NT | Per-timer single-cycle underflow pulse |

## Verification
The bench sweeps reload values across every timer. It also sweeps both prescaler ratios and cascaded pairs, and compares each measured period with the product of the divider ratios and (reload+1). A timer that wrapped to 0xFF, or that reloaded one step late, would show a period off by a whole tick or more. An unavailable source code that leaked a clock would produce stray underflows. A reload write that skipped the counter would make the first underflow after enable land outside a six-cycle window. The arming tests drive the wrong edge for the selected polarity and then clear the latch, to catch a detector that reacts to any transition or a latch that cannot be cleared.

// File: rtl/tg_pkg.sv
package tg_pkg;
   typedef enum logic [1:0] {
      SRC_INSTR = 2'b00,
      SRC_PRESC = 2'b01,
      SRC_CHAIN = 2'b10,
      SRC_NONE  = 2'b11
   } tg_src_e;

   function automatic logic pick_src(input logic [1:0] sel, input logic ins,
                                     input logic psc, input logic chn);
      case (tg_src_e'(sel))
         SRC_INSTR: return ins;
         SRC_PRESC: return psc;
         SRC_CHAIN: return chn;
         default:   return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/tg_clkgen.sv
module tg_clkgen #(
   parameter int DIV_A  = 2,
   parameter int DIV_B  = 3,
   parameter int PSC_LO = 4,
   parameter int PSC_HI = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic psc_hi_sel,
   output logic instr_tick,
   output logic presc_tick
);
   localparam int AW = (DIV_A > 2) ? $clog2(DIV_A) : 1;
   localparam int BW = (DIV_B > 2) ? $clog2(DIV_B) : 1;
   localparam int PW = $clog2(PSC_HI);

   if (DIV_A < 2 || DIV_B < 1) begin : g_bad_div
      $error("tg_clkgen: divider stages out of range");
   end
   if (PSC_LO < 2 || PSC_HI <= PSC_LO) begin : g_bad_psc
      $error("tg_clkgen: prescaler ratios out of range");
   end

   logic [AW-1:0] acnt;
   logic [BW-1:0] bcnt;
   logic [PW-1:0] pcnt;
   logic [PW-1:0] plim;
   logic          a_tick;

   assign a_tick     = (acnt == AW'(DIV_A - 1));
   assign instr_tick = a_tick && (bcnt == BW'(DIV_B - 1));
   assign plim       = psc_hi_sel ? PW'(PSC_HI - 1) : PW'(PSC_LO - 1);
   assign presc_tick = instr_tick && (pcnt >= plim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acnt <= '0;
         bcnt <= '0;
         pcnt <= '0;
      end else begin
         acnt <= a_tick ? '0 : acnt + 1'b1;
         if (a_tick) bcnt <= instr_tick ? '0 : bcnt + 1'b1;
         if (instr_tick) pcnt <= presc_tick ? '0 : pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/tg_arm.sv
module tg_arm #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic both,
   input  logic rising,
   input  logic clr,
   output logic latch
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tg_arm: at least two synchroniser stages required");
   end

   logic [SYNC_STAGES:0] sh;
   logic cur, prev, rise_ev, fall_ev, hit;

   assign cur     = sh[SYNC_STAGES-1];
   assign prev    = sh[SYNC_STAGES];
   assign rise_ev = cur && !prev;
   assign fall_ev = !cur && prev;
   assign hit     = both ? (rise_ev || fall_ev) : (rising ? rise_ev : fall_ev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         latch <= 1'b0;
      end else begin
         sh <= {sh[SYNC_STAGES-1:0], pin};
         if (clr)      latch <= 1'b0;
         else if (hit) latch <= 1'b1;
      end
   end
endmodule

// File: rtl/tg_timer.sv
module tg_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         irq_clr,
   output logic [W-1:0] cnt,
   output logic [W-1:0] reload,
   output logic         uf,
   output logic         irq
);
   assign uf = tick && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         reload <= '0;
         irq    <= 1'b0;
      end else begin
         if (wr) begin
            reload <= wdata;
            cnt    <= wdata;
         end else if (tick) begin
            cnt <= uf ? reload : cnt - 1'b1;
         end
         if (uf)           irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/cascade_timer_group.sv
module cascade_timer_group #(
   parameter int N_PAIRS     = 2,
   parameter int W           = 8,
   parameter int DIV_A       = 2,
   parameter int DIV_B       = 3,
   parameter int PSC_LO      = 4,
   parameter int PSC_HI      = 16,
   parameter int SYNC_STAGES = 2,
   localparam int NT         = 2 * N_PAIRS,
   localparam int NP         = N_PAIRS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NT-1:0]   reload_we,
   input  logic [W-1:0]    reload_wdata,
   input  logic [2*NT-1:0] src_sel,
   input  logic [NT-1:0]   run_en,
   input  logic            psc_div16,
   input  logic [NP-1:0]   arm_en,
   input  logic [NP-1:0]   arm_both,
   input  logic [NP-1:0]   arm_rising,
   input  logic [NP-1:0]   arm_clr,
   input  logic [NP-1:0]   arm_pin,
   input  logic [NT-1:0]   irq_clr,
   output logic [NT-1:0]   irq_flag,
   output logic [NT-1:0]   underflow
);
   import tg_pkg::*;

   if (N_PAIRS < 1 || W < 2) begin : g_bad_cfg
      $error("cascade_timer_group: need one pair and width of two or more");
   end

   logic            instr_tick, presc_tick;
   logic [NP-1:0]   uf_lead, uf_follow, arm_latch;
   logic [NT*W-1:0] cnt_flat, rld_flat;

   tg_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .PSC_LO(PSC_LO), .PSC_HI(PSC_HI)) u_clk (
      .clk(clk), .rst_n(rst_n), .psc_hi_sel(psc_div16),
      .instr_tick(instr_tick), .presc_tick(presc_tick));

   for (genvar p = 0; p < NP; p++) begin : g_pair
      localparam int LI = 2 * p;
      localparam int FI = 2 * p + 1;
      logic tick_l, tick_f, gate_l;

      tg_arm #(.SYNC_STAGES(SYNC_STAGES)) u_arm (
         .clk(clk), .rst_n(rst_n), .pin(arm_pin[p]), .both(arm_both[p]),
         .rising(arm_rising[p]), .clr(arm_clr[p]), .latch(arm_latch[p]));

      assign gate_l = run_en[LI] && (!arm_en[p] || arm_latch[p]);
      assign tick_l = gate_l &&
                      pick_src(src_sel[2*LI +: 2], instr_tick, presc_tick, 1'b0);
      assign tick_f = run_en[FI] &&
                      pick_src(src_sel[2*FI +: 2], instr_tick, presc_tick, uf_lead[p]);

      tg_timer #(.W(W)) u_lead (
         .clk(clk), .rst_n(rst_n), .tick(tick_l), .wr(reload_we[LI]),
         .wdata(reload_wdata), .irq_clr(irq_clr[LI]),
         .cnt(cnt_flat[LI*W +: W]), .reload(rld_flat[LI*W +: W]),
         .uf(uf_lead[p]), .irq(irq_flag[LI]));

      tg_timer #(.W(W)) u_follow (
         .clk(clk), .rst_n(rst_n), .tick(tick_f), .wr(reload_we[FI]),
         .wdata(reload_wdata), .irq_clr(irq_clr[FI]),
         .cnt(cnt_flat[FI*W +: W]), .reload(rld_flat[FI*W +: W]),
         .uf(uf_follow[p]), .irq(irq_flag[FI]));

      assign underflow[LI] = uf_lead[p];
      assign underflow[FI] = uf_follow[p];
   end
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
   parameter int N_PAIRS = 2,
   parameter int W       = 8,
   localparam int NT     = 2 * N_PAIRS
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NT-1:0]   uf,
   input logic [NT-1:0]   irq,
   input logic [NT-1:0]   irq_clr,
   input logic [NT-1:0]   we,
   input logic [NT-1:0]   run,
   input logic [2*NT-1:0] sel,
   input logic [N_PAIRS-1:0] arm_en,
   input logic [N_PAIRS-1:0] latch,
   input logic [NT*W-1:0] cnt,
   input logic [NT*W-1:0] rld
);
   for (genvar i = 0; i < NT; i++) begin : g_t
      assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
         uf[i] |=> !uf[i]);
      assert_reload_on_uf_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (uf[i] && !we[i]) |=> cnt[i*W +: W] == $past(rld[i*W +: W]));
      assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
         uf[i] |=> irq[i]);
      assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (irq[i] && !irq_clr[i]) |=> irq[i]);
      assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!run[i] && !we[i]) |=> $stable(cnt[i*W +: W]));
      assert_code11_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (sel[2*i +: 2] == 2'b11) |-> !uf[i]);
      if (i % 2 == 0) begin : g_lead
         assert_code10_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[2*i +: 2] == 2'b10) |-> !uf[i]);
         assert_hold_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (arm_en[i/2] && !latch[i/2]) |-> !uf[i]);
      end
   end
endmodule

bind cascade_timer_group tg_checker #(.N_PAIRS(N_PAIRS), .W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .uf(underflow), .irq(irq_flag), .irq_clr(irq_clr),
   .we(reload_we), .run(run_en), .sel(src_sel), .arm_en(arm_en),
   .latch(arm_latch), .cnt(cnt_flat), .rld(rld_flat));

// File: tb/sim_cascade_timer_group.sv
`timescale 1ns/1ps
module sim_cascade_timer_group;
   localparam int NP = 2;
   localparam int NT = 4;
   localparam int W  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0]   reload_we = '0;
   logic [W-1:0]    reload_wdata = '0;
   logic [2*NT-1:0] src_sel = '1;
   logic [NT-1:0]   run_en = '0;
   logic            psc_div16 = 1'b0;
   logic [NP-1:0]   arm_en = '0, arm_both = '0, arm_rising = '1, arm_clr = '0, arm_pin = '0;
   logic [NT-1:0]   irq_clr = '0;
   logic [NT-1:0]   irq_flag, underflow;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cascade_timer_group u0 (
      .clk(clk), .rst_n(rst_n), .reload_we(reload_we), .reload_wdata(reload_wdata),
      .src_sel(src_sel), .run_en(run_en), .psc_div16(psc_div16), .arm_en(arm_en),
      .arm_both(arm_both), .arm_rising(arm_rising), .arm_clr(arm_clr),
      .arm_pin(arm_pin), .irq_clr(irq_clr), .irq_flag(irq_flag), .underflow(underflow));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_tmr(input int idx, input int val);
      @(negedge clk);
      reload_wdata = W'(val);
      reload_we = '0;
      reload_we[idx] = 1'b1;
      @(negedge clk);
      reload_we = '0;
   endtask

   task automatic wait_uf(input int idx, input int limit, output int cyc);
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!underflow[idx] && cyc < limit);
   endtask

   task automatic period(input int idx, input int limit, output int p);
      int d;
      wait_uf(idx, limit, d);
      wait_uf(idx, limit, d);
      wait_uf(idx, limit, p);
   endtask

   task automatic count_uf(input int idx, input int cycles, output int n);
      n = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (underflow[idx]) n++;
      end
   endtask

   task automatic set_src(input int idx, input logic [1:0] code);
      src_sel[2*idx +: 2] = code;
   endtask

   task automatic pulse_arm_clr(input int p);
      @(negedge clk);
      arm_clr[p] = 1'b1;
      @(negedge clk);
      arm_clr[p] = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int p, n, c;
      repeat (3) @(negedge clk);
      check(irq_flag == '0, "R6 reset flags", int'(irq_flag), 0);
      check(underflow == '0, "R2 reset pulses", int'(underflow), 0);
      rst_n = 1'b1;

      // R1 / R2: instruction clock period sweep on every timer
      for (int t = 0; t < NT; t++) begin
         src_sel = '1;
         set_src(t, 2'b00);
         run_en = '0;
         run_en[t] = 1'b1;
         for (int r = 0; r < 8; r++) begin
            write_tmr(t, r);
            period(t, 4000, p);
            check(p == 6 * (r + 1), (r == 0) ? "R2 reload zero" : "R1 instr period", p, 6 * (r + 1));
         end
      end

      // R6: flag stays set, clear works
      run_en = '0;
      src_sel = '1;
      repeat (4) @(negedge clk);
      check(irq_flag == 4'hF, "R6 flags sticky", int'(irq_flag), 15);
      @(negedge clk);
      irq_clr = 4'b0101;
      @(negedge clk);
      irq_clr = '0;
      check(irq_flag == 4'b1010, "R6 selective clear", int'(irq_flag), 10);

      // R3: prescaler both ratios
      for (int d = 0; d < 2; d++) begin
         psc_div16 = d[0];
         src_sel = '1;
         set_src(1, 2'b01);
         run_en = 4'b0010;
         for (int r = 0; r < 4; r++) begin
            write_tmr(1, r);
            period(1, 8000, p);
            c = 6 * (d ? 16 : 4) * (r + 1);
            check(p == c, "R3 prescaler period", p, c);
         end
      end

      // R4: cascade pairs
      for (int q = 0; q < NP; q++) begin
         for (int a = 0; a < 3; a += 2) begin
            for (int b = 1; b < 4; b += 2) begin
               src_sel = '1;
               set_src(2*q, 2'b00);
               set_src(2*q+1, 2'b10);
               run_en = '0;
               run_en[2*q] = 1'b1;
               run_en[2*q+1] = 1'b1;
               write_tmr(2*q, a);
               write_tmr(2*q+1, b);
               period(2*q+1, 8000, p);
               c = 6 * (a + 1) * (b + 1);
               check(p == c, "R4 cascade period", p, c);
            end
         end
      end

      // R4: unavailable and off codes stay silent
      src_sel = 8'b11_10_11_10;
      run_en = '1;
      write_tmr(0, 1);
      write_tmr(2, 1);
      count_uf(0, 300, n);
      check(n == 0, "R4 code10 lead timer0", n, 0);
      count_uf(2, 60, n);
      check(n == 0, "R4 code10 lead timer2", n, 0);
      count_uf(1, 60, n);
      check(n == 0, "R4 code11 off", n, 0);

      // R5: run_en low freezes
      src_sel = '1;
      set_src(0, 2'b00);
      run_en = '0;
      write_tmr(0, 2);
      count_uf(0, 300, n);
      check(n == 0, "R5 stopped", n, 0);

      // R7: write loads counter; first uf lands 55..60 cycles after enable
      write_tmr(0, 9);
      repeat (20) @(negedge clk);
      run_en[0] = 1'b1;
      wait_uf(0, 500, c);
      check(c >= 55 && c <= 60, "R7 write loads counter", c, 55);

      // R8 / R9: arming on pair 0
      write_tmr(0, 2);
      pulse_arm_clr(0);
      arm_en[0] = 1'b1;
      arm_both[0] = 1'b0;
      arm_rising[0] = 1'b1;
      count_uf(0, 200, n);
      check(n == 0, "R8 held until armed", n, 0);
      arm_pin[0] = 1'b1;
      count_uf(0, 100, n);
      check(n >= 3, "R9 rising arms", n, 5);
      pulse_arm_clr(0);
      count_uf(0, 100, n);
      check(n == 0, "R8 clear disarms", n, 0);
      arm_pin[0] = 1'b0;
      count_uf(0, 100, n);
      check(n == 0, "R9 falling ignored in rising mode", n, 0);
      arm_both[0] = 1'b1;
      arm_pin[0] = 1'b1;
      count_uf(0, 100, n);
      check(n >= 3, "R9 both-edge arms", n, 5);
      pulse_arm_clr(0);
      arm_both[0] = 1'b0;
      arm_rising[0] = 1'b0;
      arm_pin[0] = 1'b0;
      count_uf(0, 100, n);
      check(n >= 3, "R9 falling arms", n, 5);
      pulse_arm_clr(0);
      arm_pin[0] = 1'b1;
      count_uf(0, 100, n);
      check(n == 0, "R9 rising ignored in falling mode", n, 0);
      arm_en[0] = 1'b0;

      // R8 / R9: pair 1 lead timer
      src_sel = '1;
      set_src(2, 2'b00);
      run_en = 4'b0100;
      write_tmr(2, 1);
      pulse_arm_clr(1);
      arm_en[1] = 1'b1;
      arm_rising[1] = 1'b1;
      count_uf(2, 120, n);
      check(n == 0, "R8 pair1 held", n, 0);
      arm_pin[1] = 1'b1;
      count_uf(2, 120, n);
      check(n >= 5, "R9 pair1 rising arms", n, 10);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule